// File: doc/BRIEF.md
# Shared Shift-Add Constant Multiplier

This block multiplies a signed two's-complement sample by two fixed constants, seven and twenty-one, at the same time. It has no multiplier. Each product is built from left shifts that are pure wiring, plus adders and subtractors. Seven times the input is formed as eight times the input minus the input.

In the shared build, twenty-one times the input reuses that partial product: the 7x term is doubled and added to itself (14x + 7x). The shared form needs two shifted terms and two adders. The direct form needs three of each: it builds 16x + 4x + x on its own, apart from the 7x path.

A parameter picks the structure. Both structures give bit-identical results, so one can be used to check the other. A second parameter inserts a register after each of the two adder levels. The valid strobe travels through a matching two-stage pipeline, so both products and the strobe leave together. The outputs are three and five bits wider than the input, so no input value can overflow them.

Top module: `shared_const_mult`

## Requirements
- R1: `prod7` equals 7 times the signed input sample for every representable input value.
- R2: `prod21` equals 21 times the signed input sample for every representable input value.
- R3: With `DATA_W` input bits, `prod7` is `DATA_W+3` bits and `prod21` is `DATA_W+5` bits. The most negative input (-2^(DATA_W-1)) and the most positive input (2^(DATA_W-1)-1) both give exact, non-wrapped products.
- R4: The shared structure (`SHARED=1`) and the direct structure (`SHARED=0`) give bit-identical `prod7`, `prod21` and `outValid` for the same input stream.
- R5: With `PIPELINED=1`, `outValid` equals `inValid` delayed by exactly two clock cycles, and both products belong to that same sample. With `PIPELINED=0`, the outputs and `outValid` follow the inputs in the same cycle.
- R6: A synchronous active-high `rst` clears the valid pipeline. `outValid` is 0 in the cycle after any clock edge at which `rst` is high, whatever `inValid` is.
- R7: With `PIPELINED=1`, a clock edge that brings no valid sample into the output stage leaves `prod7` and `prod21` unchanged. The outputs hold the products of the last valid sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| inValid | input | 1 | Marks `inData` as a sample to process |
| inData | input | DATA_W | Signed two's-complement input sample |
| outValid | output | 1 | Marks `prod7` and `prod21` as a new result |
| prod7 | output | DATA_W+3 | Signed product 7 × sample |
| prod21 | output | DATA_W+5 | Signed product 21 × sample |

## Verification
The bench sweeps every 8-bit input value through a shared pipelined instance, a direct pipelined instance and a shared combinational instance, and then runs random and gapped streams.

- **Range extremes.** The most negative and most positive samples are the cases a too-narrow output or a zero-filled shift would wrap or turn to the wrong sign. The bench names them separately.
- **Structure equivalence.** Comparing the direct instance with the shared one every cycle catches a wrong reuse of the partial product, such as a doubling applied to the wrong term.
- **Pipeline timing.** Gaps in the stream expose an off-by-one latency, products that slip a cycle behind their strobe, or data registers that load on an empty slot instead of holding.
- **Reset.** Holding `inValid` high during reset checks that the strobe pipeline is really cleared.

// File: rtl/scm_pkg.sv
package scm_pkg;

  // Number of adder levels in either structure; one register stage per level.
  localparam int unsigned ADD_LEVELS = 2;

  // Load strobes sent from the control to the datapath registers.
  typedef struct packed {
    logic load1;  // a valid sample enters the first register stage
    logic load2;  // a valid sample enters the output register stage
  } stageStrb_t;

endpackage

// File: rtl/scm_stage_reg.sv
module scm_stage_reg #(
  parameter int unsigned WIDTH  = 8,
  parameter bit          BYPASS = 1'b0
) (
  input  logic                    clk,
  input  logic                    load,
  input  logic signed [WIDTH-1:0] d,
  output logic signed [WIDTH-1:0] q
);

  generate
    if (BYPASS) begin : g_wire
      assign q = d;
    end else begin : g_reg
      logic signed [WIDTH-1:0] held;
      always_ff @(posedge clk) begin
        if (load) held <= d;
      end
      assign q = held;
    end
  endgenerate

endmodule

// File: rtl/scm_control.sv
module scm_control
  import scm_pkg::*;
#(
  parameter bit PIPELINED = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output stageStrb_t strb,
  output logic       outValid
);

  generate
    if (PIPELINED) begin : g_pipe
      logic [ADD_LEVELS-1:0] validSr;
      logic [1:0]            warm;

      always_ff @(posedge clk) begin
        if (rst) begin
          validSr <= '0;
        end else begin
          validSr <= {validSr[ADD_LEVELS-2:0], inValid};
        end
      end

      // Counts clean cycles since reset so that the latency check never
      // looks back into the reset period.
      always_ff @(posedge clk) begin
        if (rst)               warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
      end

      assign strb.load1 = inValid;
      assign strb.load2 = validSr[0];
      assign outValid   = validSr[ADD_LEVELS-1];

      // R6: reset empties the strobe pipeline
      a_r6_reset_clears : assert property (@(posedge clk) rst |=> !outValid);

      // R5: strobe delayed by exactly two cycles
      a_r5_latency : assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (outValid == $past(inValid, 2)));
    end else begin : g_comb
      assign strb.load1 = inValid;
      assign strb.load2 = inValid;
      assign outValid   = inValid;
    end
  endgenerate

endmodule

// File: rtl/scm_datapath.sv
module scm_datapath
  import scm_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter bit          SHARED    = 1'b1,
  parameter bit          PIPELINED = 1'b1
) (
  input  logic                     clk,
  input  stageStrb_t               strb,
  input  logic signed [DATA_W-1:0] xIn,
  output logic signed [DATA_W+2:0] p7Out,
  output logic signed [DATA_W+4:0] p21Out
);

  localparam int unsigned W7  = DATA_W + 3;
  localparam int unsigned W21 = DATA_W + 5;

  // Level 1: 7x = (x << 3) - x, sign-extended before the wired shift.
  logic signed [W7-1:0]  xExt7;
  logic signed [W7-1:0]  p7L1;
  logic signed [W7-1:0]  p7S1;
  logic signed [W21-1:0] p21L2;

  assign xExt7 = W7'(xIn);
  assign p7L1  = (xExt7 <<< 3) - xExt7;

  scm_stage_reg #(.WIDTH(W7), .BYPASS(!PIPELINED)) u_reg7s1 (
    .clk(clk), .load(strb.load1), .d(p7L1), .q(p7S1)
  );

  generate
    if (SHARED) begin : g_shared
      // Level 2: 21x = (7x << 1) + 7x, reusing the level-1 product.
      logic signed [W21-1:0] p7Wide;
      assign p7Wide = W21'(p7S1);
      assign p21L2  = (p7Wide <<< 1) + p7Wide;
    end else begin : g_direct
      // Level 1: 16x + 4x; level 2: + x. Independent of the 7x path.
      logic signed [W21-1:0]    xExt21;
      logic signed [W21-1:0]    partL1;
      logic signed [W21-1:0]    partS1;
      logic signed [DATA_W-1:0] xS1;

      assign xExt21 = W21'(xIn);
      assign partL1 = (xExt21 <<< 4) + (xExt21 <<< 2);

      scm_stage_reg #(.WIDTH(W21), .BYPASS(!PIPELINED)) u_regPart (
        .clk(clk), .load(strb.load1), .d(partL1), .q(partS1)
      );
      scm_stage_reg #(.WIDTH(DATA_W), .BYPASS(!PIPELINED)) u_regX (
        .clk(clk), .load(strb.load1), .d(xIn), .q(xS1)
      );

      assign p21L2 = partS1 + W21'(xS1);
    end
  endgenerate

  // Level-2 register: both products leave together.
  scm_stage_reg #(.WIDTH(W7), .BYPASS(!PIPELINED)) u_reg7s2 (
    .clk(clk), .load(strb.load2), .d(p7S1), .q(p7Out)
  );
  scm_stage_reg #(.WIDTH(W21), .BYPASS(!PIPELINED)) u_reg21s2 (
    .clk(clk), .load(strb.load2), .d(p21L2), .q(p21Out)
  );

endmodule

// File: rtl/shared_const_mult.sv
module shared_const_mult
  import scm_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter bit          SHARED    = 1'b1,
  parameter bit          PIPELINED = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  output logic signed [DATA_W+2:0] prod7,
  output logic signed [DATA_W+4:0] prod21
);

  stageStrb_t strb;

  scm_control #(.PIPELINED(PIPELINED)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .strb(strb), .outValid(outValid)
  );

  scm_datapath #(.DATA_W(DATA_W), .SHARED(SHARED), .PIPELINED(PIPELINED)) u_dp (
    .clk(clk), .strb(strb), .xIn(inData), .p7Out(prod7), .p21Out(prod21)
  );

  generate
    if (PIPELINED) begin : g_chkPipe
      // R1 and R3: exact 7x of the sample taken two cycles earlier
      a_r1_times7 : assert property (@(posedge clk) disable iff (rst)
        outValid |-> (prod7 == 7 * $past(inData, 2)));
      // R2 and R3: exact 21x of the same sample
      a_r2_times21 : assert property (@(posedge clk) disable iff (rst)
        outValid |-> (prod21 == 21 * $past(inData, 2)));
      // R7: without a valid sample entering, the outputs hold
      a_r7_hold : assert property (@(posedge clk) disable iff (rst)
        !strb.load2 |=> ($stable(prod7) && $stable(prod21)));
    end else begin : g_chkComb
      always_comb begin
        if (inValid) begin
          a_r1_comb7 : assert (prod7 == 7 * inData);
          a_r2_comb21 : assert (prod21 == 21 * inData);
        end
      end
    end
  endgenerate

endmodule

// File: tb/shared_const_mult_tb.sv
module shared_const_mult_tb;

  localparam int unsigned N          = 8;
  localparam int          CLK_PERIOD = 10;
  localparam int          MIN_X      = -(1 <<< (N - 1));
  localparam int          MAX_X      = (1 <<< (N - 1)) - 1;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                inValid = 1'b0;
  logic signed [N-1:0] inData = '0;

  logic                vS, vD, vC;
  logic signed [N+2:0] p7S, p7D, p7C;
  logic signed [N+4:0] p21S, p21D, p21C;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  // bench model of the two-cycle delay and the held result
  bit h1v = 1'b0, h2v = 1'b0, haveHeld = 1'b0;
  int h1x = 0, h2x = 0, held7 = 0, held21 = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shared_const_mult #(.DATA_W(N), .SHARED(1'b1), .PIPELINED(1'b1)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(vS), .prod7(p7S), .prod21(p21S)
  );
  shared_const_mult #(.DATA_W(N), .SHARED(1'b0), .PIPELINED(1'b1)) u_direct (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(vD), .prod7(p7D), .prod21(p21D)
  );
  shared_const_mult #(.DATA_W(N), .SHARED(1'b1), .PIPELINED(1'b0)) u_comb (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(vC), .prod7(p7C), .prod21(p21C)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: sample pipelined outputs, then drive the next input.
  task automatic step(input bit v, input int x);
    string rq;
    @(negedge clk);
    check(vS == h2v, "R5 shared outValid", int'(vS), int'(h2v));
    check(vD == vS, "R4 direct outValid", int'(vD), int'(vS));
    if (h2v) begin
      rq = (h2x == MIN_X || h2x == MAX_X) ? "R3" : "R1";
      check(int'(p7S) == 7 * h2x, rq, int'(p7S), 7 * h2x);
      rq = (h2x == MIN_X || h2x == MAX_X) ? "R3" : "R2";
      check(int'(p21S) == 21 * h2x, rq, int'(p21S), 21 * h2x);
      check(p7D == p7S, "R4 prod7", int'(p7D), int'(p7S));
      check(p21D == p21S, "R4 prod21", int'(p21D), int'(p21S));
      held7 = 7 * h2x;
      held21 = 21 * h2x;
      haveHeld = 1'b1;
    end else if (haveHeld) begin
      check(int'(p7S) == held7, "R7 hold prod7", int'(p7S), held7);
      check(int'(p21S) == held21, "R7 hold prod21", int'(p21S), held21);
    end
    h2v = h1v; h2x = h1x;
    h1v = v;   h1x = x;
    inValid = v;
    inData  = N'(x);
    #1;
    check(vC == v, "R5 comb outValid", int'(vC), int'(v));
    if (v) begin
      check(int'(p7C) == 7 * x, "R1 comb", int'(p7C), 7 * x);
      check(int'(p21C) == 21 * x, "R2 comb", int'(p21C), 21 * x);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    // R6: valid held high during reset must not reach the output
    inValid = 1'b1;
    inData  = 8'sd5;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(vS == 1'b0, "R6 shared outValid in reset", int'(vS), 0);
      check(vD == 1'b0, "R6 direct outValid in reset", int'(vD), 0);
    end
    rst = 1'b0;
    inValid = 1'b0;

    // exhaustive sweep, back to back (R1, R2, R3, R4, R5)
    for (int x = MIN_X; x <= MAX_X; x++) step(1'b1, x);
    // idle cycles: products must hold (R7)
    for (int i = 0; i < 4; i++) step(1'b0, 0);
    // gapped random stream
    for (int i = 0; i < 400; i++) begin
      int rx;
      rx = int'($urandom_range(255)) - 128;
      step(($urandom_range(2) != 0), rx);
    end
    // extremes and small values with gaps (R3)
    step(1'b1, MIN_X); step(1'b0, 3);
    step(1'b1, MAX_X); step(1'b0, -3);
    step(1'b1, 0);     step(1'b1, -1);
    step(1'b1, 1);     step(1'b0, 0);
    step(1'b1, MAX_X); step(1'b1, MIN_X);
    for (int i = 0; i < 4; i++) step(1'b0, 0);

    // reset mid-stream clears the pipeline (R6)
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b1;
    @(negedge clk);
    check(vS == 1'b0, "R6 outValid after reset edge", int'(vS), 0);
    @(negedge clk);
    check(vS == 1'b0, "R6 outValid second reset cycle", int'(vS), 0);
    rst = 1'b0;
    inValid = 1'b0;
    h1v = 1'b0;
    h2v = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule